// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds a table of small saturating counters. The table is addressed by a field of the branch address joined with a global record of recent branch outcomes. Because the recent behaviour of other branches chooses which counter answers, branches whose direction depends on earlier branches can be predicted correctly. A plain per-address table cannot capture that pattern.

The lookup port is combinational. The decode stage presents a branch address and receives a direction at once, together with the history value that formed the index. The pipeline carries that history value with the branch. When the branch resolves, the update port receives the same address, the real outcome and the carried history. The addressed counter then moves one step, and the outcome is shifted into the global history. With the history width set to zero, the block becomes a plain per-address counter table. The history-width parameter selects the history variant.

Top module: `corr_bpred`

## Requirements
- R1: After reset every counter holds 2^(n-1) (binary 10 for n=2), so every lookup predicts taken, and the global history reads all zeros.
- R2: The prediction is taken (1) exactly when the addressed counter is at least 2^(n-1), which is when its top bit is set.
- R3: A resolved taken branch adds one to its counter, which stops at 2^n-1 and never wraps to zero.
- R4: A resolved not-taken branch subtracts one from its counter, which stops at 0 and never wraps to the maximum.
- R5: A counter is addressed by {pc[PC_LSB+ADDR_BITS-1:PC_LSB], history}, with the history in the low bits. An update addresses its counter with the history supplied on the update port, not with the current history register.
- R6: Each update shifts its outcome into history bit 0 (1 = taken), and older bits move one place up. Without an update, the history does not change. lk_hist shows the current history.
- R7: When a lookup and an update address the same counter in one cycle, the lookup returns the value from before the update. The new value is visible from the next cycle.
- R8: Counters that share an address field but differ in history are independent. Training one counter leaves the prediction of another counter unchanged.
- R9: PC bits outside the index field have no effect. Two addresses that differ only above the field give the same prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | PC_W | Address of the branch being predicted |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | HIST_W | Current global history, to be carried with the branch |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Real outcome, 1 = taken |
| up_hist | input | HIST_W | History captured when the branch was predicted |

## Verification
The hardest case to reach from the ports is a counter that is addressed by a history different from the live history register. Every update also shifts the history, so the bench cannot read a trained counter directly after training it. To reach that case, the bench sends updates that carry an arbitrary captured history. It then steers the live history to a chosen value with updates on an unrelated scratch address, so that a lookup lands on the intended counter. Saturation at both ends is then shown by a single step back from the limit, because a wrapped counter would predict the opposite direction.

// File: rtl/bp_pkg.sv
package bp_pkg;

   // One saturating step of a direction counter whose ceiling is top.
   function automatic int unsigned ctr_step(input int unsigned cur,
                                            input logic inc,
                                            input int unsigned top);
      if (inc)
         return (cur >= top) ? top : cur + 1;
      else
         return (cur == 0) ? 0 : cur - 1;
   endfunction

endpackage

// File: rtl/bp_ghist.sv
module bp_ghist #(
   parameter int HIST_BITS = 2,
   localparam int HIST_W   = (HIST_BITS > 0) ? HIST_BITS : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sh_en,
   input  logic              sh_taken,
   output logic [HIST_W-1:0] hist
);

   generate
      if (HIST_BITS == 0) begin : g_none
         assign hist = '0;
      end else if (HIST_BITS == 1) begin : g_one
         logic hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     hist_q <= 1'b0;
            else if (sh_en) hist_q <= sh_taken;
         end
         assign hist = hist_q;

         p_shift_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
            sh_en |=> (hist[0] == $past(sh_taken)));
         p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !sh_en |=> $stable(hist));
      end else begin : g_multi
         logic [HIST_BITS-1:0] hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     hist_q <= '0;
            else if (sh_en) hist_q <= {hist_q[HIST_BITS-2:0], sh_taken};
         end
         assign hist = hist_q;

         p_shift_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
            sh_en |=> (hist[0] == $past(sh_taken)));
         p_age_r6: assert property (@(posedge clk) disable iff (!rst_n)
            sh_en |=> (hist[HIST_BITS-1:1] == $past(hist[HIST_BITS-2:0])));
         p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !sh_en |=> $stable(hist));
      end
   endgenerate

endmodule

// File: rtl/bp_index.sv
module bp_index #(
   parameter int ADDR_BITS = 4,
   parameter int HIST_BITS = 2,
   localparam int HIST_W   = (HIST_BITS > 0) ? HIST_BITS : 1,
   localparam int IDX_W    = ADDR_BITS + HIST_BITS
) (
   input  logic [ADDR_BITS-1:0] addr_field,
   input  logic [HIST_W-1:0]    hist,
   output logic [IDX_W-1:0]     idx
);

   generate
      if (HIST_BITS == 0) begin : g_addr_only
         assign idx = addr_field;
      end else begin : g_joined
         assign idx = {addr_field, hist[HIST_BITS-1:0]};
      end
   endgenerate

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
   import bp_pkg::*;
#(
   parameter int IDX_W    = 6,
   parameter int CTR_BITS = 2,
   localparam int DEPTH   = 1 << IDX_W,
   localparam int CTR_MAX = (1 << CTR_BITS) - 1,
   localparam int CTR_INI = 1 << (CTR_BITS - 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [CTR_BITS-1:0] rd_ctr,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic                wr_taken
);

   logic [DEPTH*CTR_BITS-1:0] tbl_flat;
   logic [CTR_BITS-1:0]       wr_cur;
   logic [CTR_BITS-1:0]       wr_nxt;

   assign wr_cur = tbl_flat[wr_idx*CTR_BITS +: CTR_BITS];
   assign wr_nxt = CTR_BITS'(ctr_step(int'(wr_cur), wr_taken, CTR_MAX));
   assign rd_ctr = tbl_flat[rd_idx*CTR_BITS +: CTR_BITS];

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      logic [CTR_BITS-1:0] ctr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ctr_q <= CTR_BITS'(CTR_INI);
         else if (wr_en && (wr_idx == IDX_W'(e)))
            ctr_q <= wr_nxt;
      end
      assign tbl_flat[e*CTR_BITS +: CTR_BITS] = ctr_q;
   end

   p_inc_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_taken) |=>
         (int'(tbl_flat[$past(wr_idx)*CTR_BITS +: CTR_BITS]) ==
          ((int'($past(wr_cur)) == CTR_MAX) ? CTR_MAX : int'($past(wr_cur)) + 1)));

   p_dec_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_taken) |=>
         (int'(tbl_flat[$past(wr_idx)*CTR_BITS +: CTR_BITS]) ==
          ((int'($past(wr_cur)) == 0) ? 0 : int'($past(wr_cur)) - 1)));

endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
   parameter int PC_W      = 32,
   parameter int PC_LSB    = 2,
   parameter int ADDR_BITS = 4,
   parameter int HIST_BITS = 2,
   parameter int CTR_BITS  = 2,
   localparam int HIST_W   = (HIST_BITS > 0) ? HIST_BITS : 1,
   localparam int IDX_W    = ADDR_BITS + HIST_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   lk_pc,
   output logic              lk_taken,
   output logic [HIST_W-1:0] lk_hist,
   input  logic              up_valid,
   input  logic [PC_W-1:0]   up_pc,
   input  logic              up_taken,
   input  logic [HIST_W-1:0] up_hist
);

   generate
      if (CTR_BITS < 1 || CTR_BITS > 8) begin : g_bad_ctr
         $error("corr_bpred: CTR_BITS must lie in 1..8");
      end
      if (HIST_BITS < 0 || ADDR_BITS < 1 || IDX_W > 12) begin : g_bad_idx
         $error("corr_bpred: index must be 1..12 bits");
      end
      if (PC_LSB + ADDR_BITS > PC_W) begin : g_bad_pc
         $error("corr_bpred: address field exceeds PC width");
      end
   endgenerate

   logic [IDX_W-1:0]    lk_idx;
   logic [IDX_W-1:0]    up_idx;
   logic [CTR_BITS-1:0] lk_ctr;

   bp_ghist #(.HIST_BITS(HIST_BITS)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .sh_en    (up_valid),
      .sh_taken (up_taken),
      .hist     (lk_hist)
   );

   bp_index #(.ADDR_BITS(ADDR_BITS), .HIST_BITS(HIST_BITS)) u_lk_idx (
      .addr_field (lk_pc[PC_LSB +: ADDR_BITS]),
      .hist       (lk_hist),
      .idx        (lk_idx)
   );

   bp_index #(.ADDR_BITS(ADDR_BITS), .HIST_BITS(HIST_BITS)) u_up_idx (
      .addr_field (up_pc[PC_LSB +: ADDR_BITS]),
      .hist       (up_hist),
      .idx        (up_idx)
   );

   bp_ctr_table #(.IDX_W(IDX_W), .CTR_BITS(CTR_BITS)) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (lk_idx),
      .rd_ctr   (lk_ctr),
      .wr_en    (up_valid),
      .wr_idx   (up_idx),
      .wr_taken (up_taken)
   );

   assign lk_taken = lk_ctr[CTR_BITS-1];

endmodule

// File: tb/corr_bpred_tb.sv
`timescale 1ns/1ps
module corr_bpred_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_taken;
   logic [1:0]  lk_hist;
   logic        up_valid = 1'b0;
   logic [31:0] up_pc = '0;
   logic        up_taken = 1'b0;
   logic [1:0]  up_hist = '0;

   int checks = 0;
   int errors = 0;
   int mc[64];
   logic [1:0] mh = '0;

   localparam logic [31:0] PC_A = 32'h0000_0100;
   localparam logic [31:0] PC_B = 32'h0000_0104;
   localparam logic [31:0] PC_S = 32'h0000_013C;

   always #4 clk = ~clk;

   corr_bpred u_dut (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
      .lk_hist(lk_hist), .up_valid(up_valid), .up_pc(up_pc),
      .up_taken(up_taken), .up_hist(up_hist)
   );

   function automatic int midx(input logic [31:0] pc, input logic [1:0] h);
      return int'({pc[5:2], h});
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_update(input logic [31:0] pc, input logic t, input logic [1:0] h);
      int i;
      @(negedge clk);
      up_valid = 1'b1; up_pc = pc; up_taken = t; up_hist = h;
      @(posedge clk); #1;
      up_valid = 1'b0;
      i = midx(pc, h);
      if (t && mc[i] < 3) mc[i]++;
      else if (!t && mc[i] > 0) mc[i]--;
      mh = {mh[0], t};
   endtask

   task automatic set_hist(input logic [1:0] h);
      do_update(PC_S, h[1], 2'b00);
      do_update(PC_S, h[0], 2'b00);
   endtask

   task automatic check_pred(input logic [31:0] pc, input string req);
      logic exp;
      @(negedge clk);
      lk_pc = pc;
      #1;
      exp = (mc[midx(pc, mh)] >= 2);
      check(lk_taken == exp, req, int'(lk_taken), int'(exp));
      check(lk_hist == mh, "R6", int'(lk_hist), int'(mh));
   endtask

   task automatic t_reset;
      check_pred(PC_A, "R1");
      check_pred(PC_B, "R1");
      check(lk_hist == 2'b00, "R1", int'(lk_hist), 0);
   endtask

   task automatic t_sat_high;   // R3
      for (int k = 0; k < 3; k++) do_update(PC_A, 1'b1, 2'b11);
      check_pred(PC_A, "R3");
      do_update(PC_A, 1'b0, 2'b11);
      set_hist(2'b11);
      check_pred(PC_A, "R3");
      do_update(PC_A, 1'b0, 2'b11);
      set_hist(2'b11);
      check_pred(PC_A, "R3");
   endtask

   task automatic t_sat_low;    // R4 and R2
      for (int k = 0; k < 3; k++) do_update(PC_B, 1'b0, 2'b00);
      check_pred(PC_B, "R4");
      do_update(PC_B, 1'b1, 2'b00);
      set_hist(2'b00);
      check_pred(PC_B, "R4");
      do_update(PC_B, 1'b1, 2'b00);
      set_hist(2'b00);
      check_pred(PC_B, "R2");
   endtask

   task automatic t_hist_select; // R5 and R8
      set_hist(2'b11);
      do_update(PC_A, 1'b1, 2'b00);
      do_update(PC_A, 1'b0, 2'b01);
      do_update(PC_A, 1'b0, 2'b01);
      set_hist(2'b01);
      check_pred(PC_A, "R5");
      set_hist(2'b00);
      check_pred(PC_A, "R8");
      set_hist(2'b10);
      check_pred(PC_A, "R8");
   endtask

   task automatic t_shift;       // R6
      do_update(PC_B, 1'b1, 2'b00);
      check(lk_hist[0] == 1'b1, "R6", int'(lk_hist), int'(mh));
      do_update(PC_B, 1'b0, 2'b00);
      check(lk_hist == 2'b10, "R6", int'(lk_hist), 2);
      repeat (3) @(posedge clk);
      #1;
      check(lk_hist == 2'b10, "R6", int'(lk_hist), 2);
   endtask

   task automatic t_same_cycle;  // R7
      logic old;
      set_hist(2'b10);
      old = (mc[midx(PC_A, 2'b10)] >= 2);
      @(negedge clk);
      lk_pc = PC_A;
      up_valid = 1'b1; up_pc = PC_A; up_taken = 1'b0; up_hist = 2'b10;
      #1;
      check(lk_taken == old, "R7", int'(lk_taken), int'(old));
      @(posedge clk); #1;
      up_valid = 1'b0;
      if (mc[midx(PC_A, 2'b10)] > 0) mc[midx(PC_A, 2'b10)]--;
      mh = {mh[0], 1'b0};
      set_hist(2'b10);
      check_pred(PC_A, "R7");
   endtask

   task automatic t_alias;       // R9
      for (int h = 0; h < 4; h++) begin
         set_hist(2'(h));
         check_pred(PC_A + 32'h40, "R9");
         check_pred(PC_A | 32'hFFFF_0003, "R9");
      end
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mc[i] = 2;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_sat_high();
      t_sat_low();
      t_hist_select();
      t_shift();
      t_same_cycle();
      t_alias();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule